// File: doc/BRIEF.md
# I2C Bus Clock Prescaler

This block derives the bit timing of an I2C master from a fast system clock. A configuration word carries two small fields, a 3-bit exponent N and a 4-bit mantissa M. A chain of two dividers turns them into an oversample tick. The tick is one system clock wide and runs at ten times the SCL rate. A phase signal for the bit engine is also produced. It flips on every fifth tick, so one full SCL period spans ten ticks.

Two exponent conventions are supported and selected by a mode input. In the default convention the exponent stage divides by 2^(N+1). In the alternate convention it divides by 2^N. The SCL rate is therefore the system clock divided by 10·(M+1)·2^(N+1) in the default convention, and by 10·(M+1)·2^N in the alternate one.

The dividers are free-running. A new configuration, together with the mode, is adopted only when a tick is issued, or at any time while the block is disabled. Because of this, a tick interval never ends early. The reset configuration gives a 100 kHz SCL from a 40 MHz system clock in the default convention.

Top module: `i2cRatePrescaler`

## Requirements
- R1: On a cycle with `cfgWrite` high, the block stores N from `cfgWord[2:0]` and M from `cfgWord[6:3]` as the pending configuration.
- R2: With `altMode` adopted as 0, ticks on `sampleTick` repeat every (M+1)·2^(N+1) system clocks.
- R3: With `altMode` adopted as 1, ticks repeat every (M+1)·2^N system clocks. For N=0 and M=0 this is one clock, so a tick is issued on every cycle.
- R4: After reset the configuration is N=2, M=4, default convention, giving a tick period of 40 clocks.
- R5: When the period is two clocks or more, each tick is high for exactly one system clock.
- R6: `sclPhase` is 0 after reset and flips in the same cycle as every fifth tick. It therefore stays in each state for five ticks.
- R7: A configuration or mode change made while the block is enabled is adopted at the next tick. The interval in progress completes at the old length.
- R8: While `ctrlEnable` is low, no tick is issued, `sclPhase` is held at 0 and all counters are cleared. After `ctrlEnable` rises, the first tick appears on the P-th rising clock edge, where P is the adopted period.
- R9: A configuration written while the block is disabled governs the first interval after the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlEnable | input | 1 | Runs the dividers when high; holds them cleared when low |
| altMode | input | 1 | Exponent convention: 0 divides by 2^(N+1), 1 divides by 2^N |
| cfgWrite | input | 1 | Stores `cfgWord` as the pending configuration |
| cfgWord | input | 7 | Exponent N in bits [2:0], mantissa M in bits [6:3] |
| sampleTick | output | 1 | One-cycle oversample tick at ten times the SCL rate |
| sclPhase | output | 1 | SCL half-period phase; flips every fifth tick |

## Verification
A wrong counter limit or a miscounted exponent shows up as a tick-to-tick spacing that differs from the arithmetic period. The error is visible within one interval after the configuration is adopted, so the bench measures that spacing across every mantissa, low exponents and both conventions. An early adoption of a new configuration shortens the interval in progress, which is visible at the very next tick. A slip in the phase counter moves the `sclPhase` flip away from tick five, ten and so on, and is caught within ten ticks. A counter that is not cleared while disabled shows as an early first tick after enable.

// File: rtl/i2cRatePkg.sv
package i2cRatePkg;

  // Strobes from the control half to the divider datapath.
  typedef struct packed {
    logic clear;  // hold every counter at zero
    logic run;    // advance the exponent stage this cycle
  } rateStrobe_t;

endpackage

// File: rtl/i2cRateTermCounter.sv
module i2cRateTermCounter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         term
);

  logic [W-1:0] count;

  assign term = step && (count == limit);

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      count <= '0;
    end else if (step) begin
      count <= term ? '0 : count + 1'b1;
    end
  end

endmodule

// File: rtl/i2cRateCtrl.sv
module i2cRateCtrl
  import i2cRatePkg::*;
#(
  parameter int N_W   = 3,
  parameter int M_W   = 4,
  parameter int DEF_N = 2,
  parameter int DEF_M = 4,
  localparam int PRE_W = 1 << N_W,
  localparam int EXP_W = N_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlEnable,
  input  logic               altMode,
  input  logic               cfgWrite,
  input  logic [N_W+M_W-1:0] cfgWord,
  input  logic               chainTerm,
  output rateStrobe_t        strobe,
  output logic [PRE_W-1:0]   preLimit,
  output logic [M_W-1:0]     manLimit
);

  localparam logic [EXP_W-1:0] PRE_W_E = EXP_W'(PRE_W);

  logic [N_W-1:0]   pendN, actN;
  logic [M_W-1:0]   pendM, actM;
  logic             actAlt;
  logic             loadNow;
  logic [EXP_W-1:0] expAct;
  logic [EXP_W-1:0] shiftAmt;
  logic [PRE_W-1:0] allOnes;

  // Pending configuration, written at any time.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendN <= N_W'(DEF_N);
      pendM <= M_W'(DEF_M);
    end else if (cfgWrite) begin
      pendN <= cfgWord[N_W-1:0];
      pendM <= cfgWord[N_W+M_W-1:N_W];
    end
  end

  // Adopted configuration: only at a tick boundary or while disabled.
  assign loadNow = !ctrlEnable || chainTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actN   <= N_W'(DEF_N);
      actM   <= M_W'(DEF_M);
      actAlt <= 1'b0;
    end else if (loadNow) begin
      actN   <= pendN;
      actM   <= pendM;
      actAlt <= altMode;
    end
  end

  assign expAct   = actAlt ? {1'b0, actN} : ({1'b0, actN} + 1'b1);
  assign shiftAmt = PRE_W_E - expAct;
  assign allOnes  = '1;
  assign preLimit = allOnes >> shiftAmt;
  assign manLimit = actM;

  assign strobe.clear = !ctrlEnable;
  assign strobe.run   = ctrlEnable;

endmodule

// File: rtl/i2cRateDatapath.sv
module i2cRateDatapath
  import i2cRatePkg::*;
#(
  parameter int N_W  = 3,
  parameter int M_W  = 4,
  parameter int HALF = 5,
  localparam int PRE_W = 1 << N_W,
  localparam int PH_W  = $clog2(HALF + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rateStrobe_t      strobe,
  input  logic [PRE_W-1:0] preLimit,
  input  logic [M_W-1:0]   manLimit,
  output logic             chainTerm,
  output logic             sampleTick,
  output logic             sclPhase
);

  localparam int STAGES = 3;
  localparam logic [PH_W-1:0] PH_LIMIT = PH_W'(HALF - 1);

  logic [STAGES:0] stepChain;

  assign stepChain[0] = strobe.run;

  // Stage 0: exponent, stage 1: mantissa, stage 2: ticks per SCL half.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_exp
      i2cRateTermCounter #(.W(PRE_W)) i_cnt (
        .clk(clk), .rstN(rstN), .clear(strobe.clear),
        .step(stepChain[s]), .limit(preLimit), .term(stepChain[s+1])
      );
    end else if (s == 1) begin : g_man
      i2cRateTermCounter #(.W(M_W)) i_cnt (
        .clk(clk), .rstN(rstN), .clear(strobe.clear),
        .step(stepChain[s]), .limit(manLimit), .term(stepChain[s+1])
      );
    end else begin : g_half
      i2cRateTermCounter #(.W(PH_W)) i_cnt (
        .clk(clk), .rstN(rstN), .clear(strobe.clear),
        .step(stepChain[s]), .limit(PH_LIMIT), .term(stepChain[s+1])
      );
    end
  end

  assign chainTerm = stepChain[2];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      sampleTick <= 1'b0;
      sclPhase   <= 1'b0;
    end else begin
      sampleTick <= chainTerm;
      if (stepChain[3]) sclPhase <= !sclPhase;
    end
  end

endmodule

// File: rtl/i2cRatePrescaler.sv
module i2cRatePrescaler
  import i2cRatePkg::*;
#(
  parameter int N_W   = 3,
  parameter int M_W   = 4,
  parameter int HALF  = 5,
  parameter int DEF_N = 2,
  parameter int DEF_M = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlEnable,
  input  logic               altMode,
  input  logic               cfgWrite,
  input  logic [N_W+M_W-1:0] cfgWord,
  output logic               sampleTick,
  output logic               sclPhase
);

  localparam int PRE_W = 1 << N_W;

  rateStrobe_t      strobe;
  logic [PRE_W-1:0] preLimit;
  logic [M_W-1:0]   manLimit;
  logic             chainTerm;

  i2cRateCtrl #(.N_W(N_W), .M_W(M_W), .DEF_N(DEF_N), .DEF_M(DEF_M)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .altMode(altMode),
    .cfgWrite(cfgWrite), .cfgWord(cfgWord), .chainTerm(chainTerm),
    .strobe(strobe), .preLimit(preLimit), .manLimit(manLimit)
  );

  i2cRateDatapath #(.N_W(N_W), .M_W(M_W), .HALF(HALF)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preLimit(preLimit),
    .manLimit(manLimit), .chainTerm(chainTerm),
    .sampleTick(sampleTick), .sclPhase(sclPhase)
  );

endmodule

// File: rtl/i2cRatePrescalerChecker.sv
module i2cRatePrescalerChecker #(
  parameter int N_W  = 3,
  parameter int M_W  = 4,
  parameter int HALF = 5,
  localparam int PRE_W = 1 << N_W,
  localparam int CW    = $clog2(HALF + 2)
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlEnable,
  input logic             sampleTick,
  input logic             sclPhase,
  input logic [PRE_W-1:0] preLimit,
  input logic [M_W-1:0]   manLimit
);

  logic          prevPhase;
  logic [CW-1:0] sinceFlip;

  always_ff @(posedge clk) begin
    if (!rstN || !ctrlEnable) begin
      prevPhase <= 1'b0;
      sinceFlip <= '0;
    end else begin
      prevPhase <= sclPhase;
      if (sclPhase != prevPhase) sinceFlip <= '0;
      else if (sampleTick)       sinceFlip <= sinceFlip + 1'b1;
    end
  end

  // R8: a disabled block is silent on the next cycle
  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |=> (!sampleTick && !sclPhase));

  // R6: the phase only moves together with a tick while running
  a_r6_flip_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sclPhase) && $past(ctrlEnable)) |-> sampleTick);

  // R6: no more than HALF-1 ticks pass without a flip
  a_r6_half_count: assert property (@(posedge clk) disable iff (!rstN)
    sinceFlip <= CW'(HALF - 1));

  // R7: the adopted limits move only at a tick or while disabled
  a_r7_limits_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(preLimit) || !$stable(manLimit)) |-> (sampleTick || !$past(ctrlEnable)));

  // R5: a tick lasts one cycle when the period is two clocks or more
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && ctrlEnable && (preLimit != '0 || manLimit != '0)) |=> !sampleTick);

endmodule

bind i2cRatePrescaler i2cRatePrescalerChecker #(.N_W(N_W), .M_W(M_W), .HALF(HALF)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .sampleTick(sampleTick),
  .sclPhase(sclPhase), .preLimit(preLimit), .manLimit(manLimit)
);

// File: tb/test_i2cRatePrescaler.sv
module test_i2cRatePrescaler;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 10000;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlEnable = 1'b0;
  logic       altMode = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [6:0] cfgWord = '0;
  logic       sampleTick;
  logic       sclPhase;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  i2cRatePrescaler i_i2cRatePrescaler (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .altMode(altMode),
    .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .sampleTick(sampleTick), .sclPhase(sclPhase)
  );

  function automatic int periodOf(int n, int m, bit alt);
    return (m + 1) << (alt ? n : n + 1);
  endfunction

  task automatic check(int got, int exp, string req);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Counts rising edges until a tick is seen at a falling edge.
  task automatic waitTick(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!sampleTick && n < WAIT_MAX);
  endtask

  task automatic writeCfg(int n, int m, bit alt);
    cfgWord  = 7'((m << 3) | n);
    altMode  = alt;
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        failures++;
        $display("FAIL R2 watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
        finishRun();
      end
    end
  end

  initial begin
    int n;
    int tickIdx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state while disabled
    check(int'(sampleTick), 0, "R8 reset tick");
    check(int'(sclPhase), 0, "R8 reset phase");

    // R4 / R8: reset config gives 40, first tick on 40th edge
    ctrlEnable = 1'b1;
    waitTick(n);
    check(n, 40, "R4 first tick after enable");
    check(int'(sclPhase), 0, "R6 phase at tick 1");
    tickIdx = 1;
    @(posedge clk);
    @(negedge clk);
    check(int'(sampleTick), 0, "R5 tick one cycle wide");
    // R6: phase pattern over twelve ticks
    for (int k = 2; k <= 12; k++) begin
      waitTick(n);
      tickIdx = k;
      if (k == 2) check(n, 39, "R2 second interval (one cycle already spent)");
      else        check(n, 40, "R2 default period 40");
      check(int'(sclPhase), (tickIdx / 5) % 2, "R6 phase follows tick count");
    end

    // R2 / R3 / R1: sweep exponents 0..4, all mantissas, both conventions
    for (int alt = 0; alt < 2; alt++) begin
      for (int nn = 0; nn <= 4; nn++) begin
        for (int mm = 0; mm < 16; mm++) begin
          writeCfg(nn, mm, alt[0]);
          waitTick(n);
          waitTick(n);
          check(n, periodOf(nn, mm, alt[0]), alt ? "R3 alt period sweep" : "R2 default period sweep");
        end
      end
    end

    // R2 / R3 / R1: largest fields
    for (int alt = 0; alt < 2; alt++) begin
      writeCfg(7, 15, alt[0]);
      waitTick(n);
      waitTick(n);
      check(n, periodOf(7, 15, alt[0]), "R1 largest fields period");
    end

    // R7: change mid-interval; old interval completes at full length
    writeCfg(2, 4, 1'b0);
    waitTick(n);
    waitTick(n);
    check(n, 40, "R7 setup period");
    repeat (9) begin
      @(posedge clk);
      @(negedge clk);
      check(int'(sampleTick), 0, "R7 no tick mid-interval");
    end
    writeCfg(1, 0, 1'b1);
    waitTick(n);
    check(n, 30, "R7 old interval not cut short");
    waitTick(n);
    check(n, 2, "R7 new period after tick");

    // R3: period of one gives a tick on every cycle
    writeCfg(0, 0, 1'b1);
    waitTick(n);
    waitTick(n);
    check(n, 1, "R3 period one");
    @(posedge clk);
    @(negedge clk);
    check(int'(sampleTick), 1, "R3 tick every cycle");

    // R8 / R9: disable, write while disabled, re-enable
    ctrlEnable = 1'b0;
    for (int k = 0; k < 50; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (sampleTick || sclPhase) break;
    end
    check(int'(sampleTick), 0, "R8 no tick while disabled");
    check(int'(sclPhase), 0, "R8 phase held low");
    writeCfg(3, 2, 1'b0);
    repeat (3) @(negedge clk);
    ctrlEnable = 1'b1;
    waitTick(n);
    check(n, periodOf(3, 2, 1'b0), "R9 disabled write governs first interval");
    check(int'(sclPhase), 0, "R8 phase restarts");

    finishRun();
  end

endmodule